// File: doc/BRIEF.md
# Forwarding Port Mask Resolver

This block takes the per-port routing mask produced by an address lookup in a ten-port switch (eight data ports, one uplink-capable fast port and a management port) and turns it into the final set of egress ports for one frame. The mask is trimmed in a fixed order. First the arrival port is removed unless it belongs to a ring. Then disabled ports and transmit-blocked ports are cleared. Finally, if the lookup entry asks for mirroring, the configured uplink port may be added.

One request is presented per cycle with `validIn`. The resolved mask appears on `maskOut` with `doneOut` high exactly one cycle later. The mask holds between requests. An all-zero result means the frame is to be dropped. Address lookup and trunk hashing are done elsewhere.

Top module: `fwd_mask_resolver`

## Requirements
- R1: While `rstN` is low and after its release, `maskOut` is all zero and `doneOut` is low until the first request.
- R2: A request sampled with `validIn` high produces `doneOut` high in the next cycle. `doneOut` is low in every other cycle, and `maskOut` keeps its value in cycles that follow a cycle without a request.
- R3: The bit of the arrival port `srcPort` (bit index equals port number) is cleared from the result when that port's bit in `ringMask` is 0.
- R4: When the arrival port's bit in `ringMask` is 1, the arrival port stays in the result if the lookup mask contains it.
- R5: A port whose bit in `enMask` is 0 is never set in the result.
- R6: A port whose bit in `txBlockMask` is 1 is cleared from the result, unless it is the uplink port being added by mirroring.
- R7: With `mirrorFlag` high, the uplink port is added when the arrival port equals `mirrorPort`.
- R8: With `mirrorFlag` high, the uplink port is added when the mask still contains the mirror port after source, disabled and blocked ports are removed. A mirror port removed by those steps does not cause the addition.
- R9: The uplink port is not added when `mirrorFlag` is low or when the arrival port equals `uplinkPort`.
- R10: The added uplink port is still cleared if it is disabled in `enMask`, but it is not cleared by `txBlockMask`.
- R11: A port index of 10 or above in `srcPort`, `mirrorPort` or `uplinkPort` selects no port. Such an index removes nothing, matches nothing and adds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Request strobe, one frame per cycle |
| srcPort | input | 4 | Arrival port index |
| lookupMask | input | 10 | Routing mask from the address lookup |
| ringMask | input | 10 | Ports configured as ring ports |
| enMask | input | 10 | Enabled ports |
| txBlockMask | input | 10 | Ports blocked from transmitting |
| mirrorPort | input | 4 | Monitored port index |
| uplinkPort | input | 4 | Port that receives mirrored copies |
| mirrorFlag | input | 1 | Lookup entry requests mirroring |
| maskOut | output | 10 | Resolved egress mask, zero means drop |
| doneOut | output | 1 | Result valid strobe |

## Verification
The result register sits one stage behind the inputs, so a fault in any trimming step shows on `maskOut` in the cycle `doneOut` rises for the offending request. Because no other state exists, nothing hides until later. A wrong strobe register shows as `doneOut` misaligned with the request, or as `maskOut` changing in a cycle without a request. The vectors isolate each trimming step with masks where only that step makes a difference. For mirroring, the case where the mirror port is blocked is the one that exposes an evaluation done in the wrong order.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;    // load the resolved mask this cycle
    logic mirrorArm;  // mirroring may add the uplink for this request
  } ctrlStrobes_t;

endpackage

// File: rtl/fwd_mask_ctrl.sv
module fwd_mask_ctrl
  import fwd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         validIn,
  input  logic         mirrorFlag,
  output ctrlStrobes_t strobes,
  output logic         doneOut
);

  logic doneQ;

  always_comb begin
    strobes.capture   = validIn;
    strobes.mirrorArm = validIn & mirrorFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= validIn;
  end

  assign doneOut = doneQ;

endmodule

// File: rtl/fwd_mask_dp.sv
module fwd_mask_dp
  import fwd_pkg::*;
#(
  parameter int NUM_PORTS = 10,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [PORT_W-1:0]    srcPort,
  input  logic [NUM_PORTS-1:0] lookupMask,
  input  logic [NUM_PORTS-1:0] ringMask,
  input  logic [NUM_PORTS-1:0] enMask,
  input  logic [NUM_PORTS-1:0] txBlockMask,
  input  logic [PORT_W-1:0]    mirrorPort,
  input  logic [PORT_W-1:0]    uplinkPort,
  output logic [NUM_PORTS-1:0] maskOut
);

  logic [NUM_PORTS-1:0] srcDec;
  logic [NUM_PORTS-1:0] mirDec;
  logic [NUM_PORTS-1:0] upDec;
  logic [NUM_PORTS-1:0] afterSrc;
  logic [NUM_PORTS-1:0] afterFilter;
  logic [NUM_PORTS-1:0] withMirror;
  logic [NUM_PORTS-1:0] maskQ;
  logic                 mirrorHit;
  logic                 srcIsUplink;
  logic                 addUplink;

  // Per-port decode and trimming; an index out of range decodes to no port.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign srcDec[p] = (srcPort    == PORT_W'(p));
    assign mirDec[p] = (mirrorPort == PORT_W'(p));
    assign upDec[p]  = (uplinkPort == PORT_W'(p));

    // Source removal, bypassed for ring ports.
    assign afterSrc[p]    = lookupMask[p] & ~(srcDec[p] & ~ringMask[p]);
    // Disabled and blocked ports.
    assign afterFilter[p] = afterSrc[p] & enMask[p] & ~txBlockMask[p];
    // Uplink copy, still gated by the enable mask.
    assign withMirror[p]  = (afterFilter[p] | (addUplink & upDec[p])) & enMask[p];
  end

  assign mirrorHit   = (|(srcDec & mirDec)) | (|(afterFilter & mirDec));
  assign srcIsUplink = |(srcDec & upDec);
  assign addUplink   = strobes.mirrorArm & mirrorHit & ~srcIsUplink;

  always_ff @(posedge clk) begin
    if (!rstN)                maskQ <= '0;
    else if (strobes.capture) maskQ <= withMirror;
  end

  assign maskOut = maskQ;

endmodule

// File: rtl/fwd_mask_resolver.sv
module fwd_mask_resolver
  import fwd_pkg::*;
#(
  parameter int NUM_PORTS = 10,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 validIn,
  input  logic [PORT_W-1:0]    srcPort,
  input  logic [NUM_PORTS-1:0] lookupMask,
  input  logic [NUM_PORTS-1:0] ringMask,
  input  logic [NUM_PORTS-1:0] enMask,
  input  logic [NUM_PORTS-1:0] txBlockMask,
  input  logic [PORT_W-1:0]    mirrorPort,
  input  logic [PORT_W-1:0]    uplinkPort,
  input  logic                 mirrorFlag,
  output logic [NUM_PORTS-1:0] maskOut,
  output logic                 doneOut
);

  ctrlStrobes_t strobes;

  fwd_mask_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .validIn    (validIn),
    .mirrorFlag (mirrorFlag),
    .strobes    (strobes),
    .doneOut    (doneOut)
  );

  fwd_mask_dp #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .srcPort     (srcPort),
    .lookupMask  (lookupMask),
    .ringMask    (ringMask),
    .enMask      (enMask),
    .txBlockMask (txBlockMask),
    .mirrorPort  (mirrorPort),
    .uplinkPort  (uplinkPort),
    .maskOut     (maskOut)
  );

endmodule

// File: rtl/fwd_mask_resolver_chk.sv
module fwd_mask_resolver_chk #(
  parameter int NUM_PORTS = 10,
  parameter int PORT_W    = $clog2(NUM_PORTS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 validIn,
  input logic [PORT_W-1:0]    srcPort,
  input logic [NUM_PORTS-1:0] lookupMask,
  input logic [NUM_PORTS-1:0] ringMask,
  input logic [NUM_PORTS-1:0] enMask,
  input logic [NUM_PORTS-1:0] txBlockMask,
  input logic [PORT_W-1:0]    uplinkPort,
  input logic                 mirrorFlag,
  input logic [NUM_PORTS-1:0] maskOut,
  input logic                 doneOut
);

  logic [NUM_PORTS-1:0] srcBit;
  logic [NUM_PORTS-1:0] upBit;

  always_comb begin
    srcBit = '0;
    upBit  = '0;
    if (int'(srcPort)    < NUM_PORTS) srcBit[srcPort]    = 1'b1;
    if (int'(uplinkPort) < NUM_PORTS) upBit[uplinkPort] = 1'b1;
  end

  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> doneOut);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> (!doneOut && $stable(maskOut)));

  // R3
  src_removed_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> ((maskOut & $past(srcBit & ~ringMask)) == '0));

  // R5
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> ((maskOut & ~$past(enMask)) == '0));

  // R6
  blocked_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> ((maskOut & $past(txBlockMask & ~upBit)) == '0));

  // R9
  no_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && !$past(mirrorFlag)) |-> ((maskOut & $past(upBit & ~lookupMask)) == '0));

endmodule

bind fwd_mask_resolver fwd_mask_resolver_chk #(
  .NUM_PORTS (NUM_PORTS),
  .PORT_W    (PORT_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .validIn     (validIn),
  .srcPort     (srcPort),
  .lookupMask  (lookupMask),
  .ringMask    (ringMask),
  .enMask      (enMask),
  .txBlockMask (txBlockMask),
  .uplinkPort  (uplinkPort),
  .mirrorFlag  (mirrorFlag),
  .maskOut     (maskOut),
  .doneOut     (doneOut)
);

// File: tb/fwd_mask_resolver_tb.sv
module fwd_mask_resolver_tb;

  localparam int N  = 10;
  localparam int PW = 4;

  typedef struct packed {
    logic [7:0]    req;
    logic [PW-1:0] src;
    logic [N-1:0]  lookup;
    logic [N-1:0]  ring;
    logic [N-1:0]  en;
    logic [N-1:0]  blk;
    logic [PW-1:0] mir;
    logic [PW-1:0] up;
    logic          flag;
    logic [N-1:0]  expMask;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // R3 plain source removal
    '{8'd3,  4'd2,  10'h3FF, 10'h000, 10'h3FF, 10'h000, 4'd15, 4'd15, 1'b0, 10'h3FB},
    // R4 ring source kept
    '{8'd4,  4'd2,  10'h3FF, 10'h004, 10'h3FF, 10'h000, 4'd15, 4'd15, 1'b0, 10'h3FF},
    // R5 disabled ports cleared
    '{8'd5,  4'd0,  10'h0F0, 10'h000, 10'h0CF, 10'h000, 4'd15, 4'd15, 1'b0, 10'h0C0},
    // R6 blocked ports cleared
    '{8'd6,  4'd0,  10'h0FE, 10'h000, 10'h3FF, 10'h00A, 4'd15, 4'd15, 1'b0, 10'h0F4},
    // R7 source is mirror port
    '{8'd7,  4'd3,  10'h001, 10'h000, 10'h3FF, 10'h000, 4'd3,  4'd9,  1'b1, 10'h201},
    // R8 mask contains mirror port
    '{8'd8,  4'd1,  10'h030, 10'h000, 10'h3FF, 10'h000, 4'd5,  4'd8,  1'b1, 10'h130},
    // R8 mirror port blocked, no uplink copy
    '{8'd8,  4'd1,  10'h030, 10'h000, 10'h3FF, 10'h020, 4'd5,  4'd8,  1'b1, 10'h010},
    // R9 source is uplink
    '{8'd9,  4'd8,  10'h130, 10'h000, 10'h3FF, 10'h000, 4'd5,  4'd8,  1'b1, 10'h030},
    // R9 flag clear
    '{8'd9,  4'd1,  10'h030, 10'h000, 10'h3FF, 10'h000, 4'd5,  4'd8,  1'b0, 10'h030},
    // R10 uplink disabled
    '{8'd10, 4'd1,  10'h030, 10'h000, 10'h0FF, 10'h000, 4'd5,  4'd8,  1'b1, 10'h030},
    // R10 uplink in block mask still added
    '{8'd10, 4'd1,  10'h030, 10'h000, 10'h3FF, 10'h100, 4'd5,  4'd8,  1'b1, 10'h130},
    // R11 uplink index out of range
    '{8'd11, 4'd1,  10'h030, 10'h000, 10'h3FF, 10'h000, 4'd5,  4'd15, 1'b1, 10'h030},
    // R11 source index out of range
    '{8'd11, 4'd12, 10'h3FF, 10'h000, 10'h3FF, 10'h000, 4'd15, 4'd15, 1'b0, 10'h3FF},
    // R3 management port as source
    '{8'd3,  4'd9,  10'h3FF, 10'h000, 10'h3FF, 10'h000, 4'd15, 4'd15, 1'b0, 10'h1FF},
    // R3 only destination is the source: drop
    '{8'd3,  4'd4,  10'h010, 10'h000, 10'h3FF, 10'h000, 4'd15, 4'd15, 1'b0, 10'h000}
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic          validIn;
  logic [PW-1:0] srcPort;
  logic [N-1:0]  lookupMask;
  logic [N-1:0]  ringMask;
  logic [N-1:0]  enMask;
  logic [N-1:0]  txBlockMask;
  logic [PW-1:0] mirrorPort;
  logic [PW-1:0] uplinkPort;
  logic          mirrorFlag;
  logic [N-1:0]  maskOut;
  logic          doneOut;

  int  tests = 0;
  int  fails = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  fwd_mask_resolver u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .validIn     (validIn),
    .srcPort     (srcPort),
    .lookupMask  (lookupMask),
    .ringMask    (ringMask),
    .enMask      (enMask),
    .txBlockMask (txBlockMask),
    .mirrorPort  (mirrorPort),
    .uplinkPort  (uplinkPort),
    .mirrorFlag  (mirrorFlag),
    .maskOut     (maskOut),
    .doneOut     (doneOut)
  );

  task automatic check(input string tag, input logic [N:0] act, input logic [N:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    srcPort     = v.src;
    lookupMask  = v.lookup;
    ringMask    = v.ring;
    enMask      = v.en;
    txBlockMask = v.blk;
    mirrorPort  = v.mir;
    uplinkPort  = v.up;
    mirrorFlag  = v.flag;
  endtask

  initial begin
    rstN = 1'b0;
    validIn = 1'b0;
    apply(VECS[0]);
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 reset", {doneOut, maskOut}, '0);
    validIn = 1'b1;
    @(negedge clk);
    check("R1 request held in reset", {doneOut, maskOut}, '0);
    validIn = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {doneOut, maskOut}, '0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      validIn = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), {doneOut, maskOut}, {1'b1, VECS[i].expMask});
    end

    // R2: no request, inputs change, result holds and strobe drops
    validIn = 1'b0;
    apply(VECS[0]);
    @(negedge clk);
    check("R2 hold after idle", {doneOut, maskOut}, {1'b0, VECS[NV-1].expMask});
    @(negedge clk);
    check("R2 still held", {doneOut, maskOut}, {1'b0, VECS[NV-1].expMask});
    // R2: single request gives one-cycle strobe
    validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    check("R2 strobe", {doneOut, maskOut}, {1'b1, VECS[0].expMask});
    @(negedge clk);
    check("R2 strobe drops", {doneOut, maskOut}, {1'b0, VECS[0].expMask});

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule